// File: doc/BRIEF.md
# Configurable PLA Logic Array

This block is a programmable logic array whose personality is loaded at run time. It evaluates several sum-of-products functions of a set of input bits. A programmable AND plane forms product terms. Each term can pick the true or the inverted copy of any input. A programmable OR plane then decides which product terms are summed into each output. One product term may feed any number of outputs. The outputs are a purely combinational function of the inputs and the stored personality.

Before operation, a narrow write port sets or clears one personality bit per clock. Outputs are then read combinationally from the input pins. A small number of outputs can be returned to the highest-numbered inputs through registers, one per feedback path. With this, a single array can build multilevel logic, for example a wide parity built from smaller parities. Each feedback level costs one clock and cannot form a combinational loop. Reset clears every personality bit, so an unprogrammed array drives all outputs low.

Top module: `cfg_pla`

## Requirements
- R1: AND-plane column 2*i selects input i in true form and column 2*i+1 selects it in inverted form. A product term is the AND of every literal selected in its row.
- R2: A product term with no literal selected evaluates to 1.
- R3: Output o is the OR of every product term whose OR-plane bit (row = term, column = o) is set. An output with no term connected is 0.
- R4: A product term that selects both the true and the inverted literal of the same input evaluates to 0.
- R5: One product term connected to several outputs drives all of them at the same time.
- R6: While cfg_en is high at a rising clock edge, the personality bit addressed by cfg_plane (0 = AND plane, 1 = OR plane), cfg_row (term index) and cfg_col takes the value of cfg_bit. A row at or beyond NUM_TERM, or a column at or beyond the plane width (2*NUM_IN for AND, NUM_OUT for OR), changes nothing.
- R7: While cfg_en is low, no personality bit changes.
- R8: At every clock, output k (k < NUM_FB) is captured in a feedback register. While fb_sel[k] is high, input NUM_IN-NUM_FB+k is taken from that register instead of its pin, and the pin value has no effect.
- R9: Reset clears all personality bits and feedback registers, so all outputs read 0 until the array is programmed.
- R10: With no feedback selected, outputs follow the input pins in the same cycle, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for personality writes and feedback registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Personality write enable |
| cfg_plane | input | 1 | Plane select: 0 AND, 1 OR |
| cfg_row | input | ROW_W | Product-term index |
| cfg_col | input | COL_W | Literal column (AND) or output index (OR) |
| cfg_bit | input | 1 | Value written to the addressed bit |
| pla_in | input | NUM_IN | Input variables |
| fb_sel | input | FB_W | Per feedback path: take the top inputs from the registered outputs |
| pla_out | output | NUM_OUT | Sum-of-products results |

## Verification
The assertions check the local laws of the array on every cycle. An empty term reads 1 and a term with a conflicting literal pair reads 0. An output with an empty OR column is low. Writes land exactly on the addressed bit, and the planes hold still while writes are disabled. The outputs stay low from reset until the first write. The bench scenarios are needed for the relations across time and programs. These include sharing of one term by several outputs and the one-cycle delay of a feedback level in a two-level parity. They also cover discarding of out-of-range addresses and the same-cycle response of the outputs to new pin values. A behavioural model compares all outputs every clock under random programs.

// File: rtl/cfg_pla_pkg.sv
package cfg_pla_pkg;
   typedef enum logic {
      PLANE_AND = 1'b0,
      PLANE_OR  = 1'b1
   } plane_e;

   function automatic int idx_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction
endpackage

// File: rtl/cfg_pla_store.sv
module cfg_pla_store #(
   parameter int ROWS  = 42,
   parameter int COLS  = 36,
   parameter int RW    = 6,
   parameter int CW    = 6,
   localparam int BITS = ROWS * COLS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RW-1:0]   row,
   input  logic [CW-1:0]   col,
   input  logic            din,
   output logic [BITS-1:0] bits
);
   logic [ROWS-1:0] row_hit;
   logic [COLS-1:0] col_hit;

   for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
      assign row_hit[r] = we && (row == RW'(r));
   end
   for (genvar c = 0; c < COLS; c++) begin : g_col_dec
      assign col_hit[c] = (col == CW'(c));
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         always_ff @(posedge clk) begin
            if (!rst_n)
               bits[r*COLS+c] <= 1'b0;
            else if (row_hit[r] && col_hit[c])
               bits[r*COLS+c] <= din;
         end
      end
   end
endmodule

// File: rtl/cfg_pla_and_plane.sv
module cfg_pla_and_plane #(
   parameter int NUM_IN   = 18,
   parameter int NUM_TERM = 42,
   localparam int LIT     = 2 * NUM_IN
) (
   input  logic [NUM_IN-1:0]       vars,
   input  logic [NUM_TERM*LIT-1:0] sel,
   output logic [NUM_TERM-1:0]     term
);
   logic [LIT-1:0] lits;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      assign lits[2*i]   = vars[i];
      assign lits[2*i+1] = ~vars[i];
   end

   for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
      assign term[t] = &(~sel[t*LIT +: LIT] | lits);
   end
endmodule

// File: rtl/cfg_pla_or_plane.sv
module cfg_pla_or_plane #(
   parameter int NUM_TERM = 42,
   parameter int NUM_OUT  = 10
) (
   input  logic [NUM_TERM-1:0]         term,
   input  logic [NUM_TERM*NUM_OUT-1:0] sel,
   output logic [NUM_OUT-1:0]          y
);
   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [NUM_TERM-1:0] col;
      for (genvar t = 0; t < NUM_TERM; t++) begin : g_pick
         assign col[t] = sel[t*NUM_OUT+o] & term[t];
      end
      assign y[o] = |col;
   end
endmodule

// File: rtl/cfg_pla_feedback.sv
module cfg_pla_feedback #(
   parameter int NUM_IN = 18,
   parameter int NUM_FB = 3,
   localparam int FB_W  = (NUM_FB > 0) ? NUM_FB : 1,
   localparam int BASE  = NUM_IN - NUM_FB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pins,
   input  logic [FB_W-1:0]   fb_sel,
   input  logic [FB_W-1:0]   fb_src,
   output logic [NUM_IN-1:0] vars
);
   if (NUM_FB == 0) begin : g_no_fb
      assign vars = pins;
   end else begin : g_fb
      logic [NUM_FB-1:0] fb_q;

      always_ff @(posedge clk) begin
         if (!rst_n) fb_q <= '0;
         else        fb_q <= fb_src;
      end

      for (genvar i = 0; i < NUM_IN; i++) begin : g_mux
         if (i >= BASE) begin : g_sw
            assign vars[i] = fb_sel[i-BASE] ? fb_q[i-BASE] : pins[i];
         end else begin : g_pass
            assign vars[i] = pins[i];
         end
      end
   end
endmodule

// File: rtl/cfg_pla.sv
module cfg_pla
   import cfg_pla_pkg::*;
#(
   parameter int NUM_IN   = 18,
   parameter int NUM_TERM = 42,
   parameter int NUM_OUT  = 10,
   parameter int NUM_FB   = 3,
   localparam int LIT     = 2 * NUM_IN,
   localparam int ROW_W   = idx_width(NUM_TERM),
   localparam int COL_W   = idx_width((LIT > NUM_OUT) ? LIT : NUM_OUT),
   localparam int FB_W    = (NUM_FB > 0) ? NUM_FB : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_en,
   input  logic               cfg_plane,
   input  logic [ROW_W-1:0]   cfg_row,
   input  logic [COL_W-1:0]   cfg_col,
   input  logic               cfg_bit,
   input  logic [NUM_IN-1:0]  pla_in,
   input  logic [FB_W-1:0]    fb_sel,
   output logic [NUM_OUT-1:0] pla_out
);
   initial begin
      if (NUM_IN < 1 || NUM_TERM < 1 || NUM_OUT < 1)
         $error("cfg_pla: every dimension must be at least 1");
      if (NUM_FB < 0 || NUM_FB > NUM_IN || NUM_FB > NUM_OUT)
         $error("cfg_pla: NUM_FB must fit both the inputs and the outputs");
   end

   logic                        we_and, we_or;
   logic [NUM_TERM*LIT-1:0]     and_bits;
   logic [NUM_TERM*NUM_OUT-1:0] or_bits;
   logic [NUM_IN-1:0]           vars;
   logic [NUM_TERM-1:0]         terms;

   assign we_and = cfg_en && (plane_e'(cfg_plane) == PLANE_AND);
   assign we_or  = cfg_en && (plane_e'(cfg_plane) == PLANE_OR);

   cfg_pla_store #(.ROWS(NUM_TERM), .COLS(LIT), .RW(ROW_W), .CW(COL_W)) u_and_store (
      .clk(clk), .rst_n(rst_n), .we(we_and), .row(cfg_row), .col(cfg_col),
      .din(cfg_bit), .bits(and_bits));

   cfg_pla_store #(.ROWS(NUM_TERM), .COLS(NUM_OUT), .RW(ROW_W), .CW(COL_W)) u_or_store (
      .clk(clk), .rst_n(rst_n), .we(we_or), .row(cfg_row), .col(cfg_col),
      .din(cfg_bit), .bits(or_bits));

   cfg_pla_feedback #(.NUM_IN(NUM_IN), .NUM_FB(NUM_FB)) u_fb (
      .clk(clk), .rst_n(rst_n), .pins(pla_in), .fb_sel(fb_sel),
      .fb_src(pla_out[FB_W-1:0]), .vars(vars));

   cfg_pla_and_plane #(.NUM_IN(NUM_IN), .NUM_TERM(NUM_TERM)) u_and (
      .vars(vars), .sel(and_bits), .term(terms));

   cfg_pla_or_plane #(.NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT)) u_or (
      .term(terms), .sel(or_bits), .y(pla_out));
endmodule

// File: rtl/cfg_pla_chk.sv
module cfg_pla_chk #(
   parameter int NUM_IN   = 18,
   parameter int NUM_TERM = 42,
   parameter int NUM_OUT  = 10,
   parameter int ROW_W    = 6,
   parameter int COL_W    = 6,
   localparam int LIT     = 2 * NUM_IN
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_en,
   input logic                        cfg_plane,
   input logic [ROW_W-1:0]            cfg_row,
   input logic [COL_W-1:0]            cfg_col,
   input logic                        cfg_bit,
   input logic [NUM_TERM*LIT-1:0]     and_bits,
   input logic [NUM_TERM*NUM_OUT-1:0] or_bits,
   input logic [NUM_TERM-1:0]         terms,
   input logic [NUM_OUT-1:0]          pla_out
);
   logic programmed;
   int   and_idx, or_idx;
   logic and_ok, or_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)      programmed <= 1'b0;
      else if (cfg_en) programmed <= 1'b1;
   end

   assign and_idx = int'(cfg_row) * LIT + int'(cfg_col);
   assign or_idx  = int'(cfg_row) * NUM_OUT + int'(cfg_col);
   assign and_ok  = cfg_en && !cfg_plane && int'(cfg_row) < NUM_TERM && int'(cfg_col) < LIT;
   assign or_ok   = cfg_en && cfg_plane && int'(cfg_row) < NUM_TERM && int'(cfg_col) < NUM_OUT;

   a_r9_clear_until_programmed: assert property (@(posedge clk) disable iff (!rst_n)
      !programmed |-> (pla_out == '0));

   a_r6_and_write: assert property (@(posedge clk) disable iff (!rst_n)
      and_ok |=> (and_bits[$past(and_idx)] == $past(cfg_bit)));

   a_r6_or_write: assert property (@(posedge clk) disable iff (!rst_n)
      or_ok |=> (or_bits[$past(or_idx)] == $past(cfg_bit)));

   a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> ($stable(and_bits) && $stable(or_bits)));

   for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
      logic [NUM_IN-1:0] clash;
      for (genvar i = 0; i < NUM_IN; i++) begin : g_pair
         assign clash[i] = and_bits[t*LIT+2*i] & and_bits[t*LIT+2*i+1];
      end
      a_r2_empty_term_true: assert property (@(posedge clk) disable iff (!rst_n)
         (and_bits[t*LIT +: LIT] == '0) |-> terms[t]);
      a_r4_clash_term_false: assert property (@(posedge clk) disable iff (!rst_n)
         (|clash) |-> !terms[t]);
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic [NUM_TERM-1:0] conn;
      for (genvar t = 0; t < NUM_TERM; t++) begin : g_c
         assign conn[t] = or_bits[t*NUM_OUT+o];
      end
      a_r3_unconnected_low: assert property (@(posedge clk) disable iff (!rst_n)
         (conn == '0) |-> !pla_out[o]);
   end
endmodule

bind cfg_pla cfg_pla_chk #(
   .NUM_IN(NUM_IN), .NUM_TERM(NUM_TERM), .NUM_OUT(NUM_OUT),
   .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_plane(cfg_plane),
   .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_bit(cfg_bit),
   .and_bits(and_bits), .or_bits(or_bits), .terms(terms), .pla_out(pla_out)
);

// File: tb/cfg_pla_tb.sv
`timescale 1ns/1ps
module cfg_pla_tb;
   localparam int NI  = 18;
   localparam int NT  = 42;
   localparam int NO  = 10;
   localparam int NF  = 3;
   localparam int LC  = 2 * NI;
   localparam int RW  = 6;
   localparam int CW  = 6;
   localparam int FBW = NF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_plane = 1'b0;
   logic [RW-1:0] cfg_row = '0;
   logic [CW-1:0] cfg_col = '0;
   logic          cfg_bit = 1'b0;
   logic [NI-1:0] pla_in = '0;
   logic [FBW-1:0] fb_sel = '0;
   logic [NO-1:0] pla_out;

   always #2.5 clk = ~clk;

   cfg_pla #(.NUM_IN(NI), .NUM_TERM(NT), .NUM_OUT(NO), .NUM_FB(NF)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_plane(cfg_plane),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_bit(cfg_bit),
      .pla_in(pla_in), .fb_sel(fb_sel), .pla_out(pla_out));

   bit    am [NT][LC];
   bit    om [NT][NO];
   bit    fbm [NF];
   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R9";

   function automatic logic [NO-1:0] model_eval(input logic [NI-1:0] pins,
                                                input logic [FBW-1:0] sel);
      bit v [NI];
      logic [NO-1:0] res = '0;
      for (int i = 0; i < NI; i++) v[i] = pins[i];
      for (int k = 0; k < NF; k++) if (sel[k]) v[NI-NF+k] = fbm[k];
      for (int t = 0; t < NT; t++) begin
         bit p = 1'b1;
         for (int i = 0; i < NI; i++) begin
            if (am[t][2*i] && !v[i]) p = 1'b0;
            if (am[t][2*i+1] && v[i]) p = 1'b0;
         end
         for (int o = 0; o < NO; o++) if (om[t][o] && p) res[o] = 1'b1;
      end
      return res;
   endfunction

   task automatic model_clear();
      for (int t = 0; t < NT; t++) begin
         for (int c = 0; c < LC; c++) am[t][c] = 1'b0;
         for (int o = 0; o < NO; o++) om[t][o] = 1'b0;
      end
      for (int k = 0; k < NF; k++) fbm[k] = 1'b0;
   endtask

   task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: update the model at the edge, compare at the falling edge
   task automatic tick();
      logic [NO-1:0] pre;
      pre = model_eval(pla_in, fb_sel);
      @(posedge clk);
      if (!rst_n) model_clear();
      else begin
         if (cfg_en) begin
            if (!cfg_plane && int'(cfg_row) < NT && int'(cfg_col) < LC)
               am[cfg_row][cfg_col] = cfg_bit;
            if (cfg_plane && int'(cfg_row) < NT && int'(cfg_col) < NO)
               om[cfg_row][cfg_col] = cfg_bit;
         end
         for (int k = 0; k < NF; k++) fbm[k] = pre[k];
      end
      @(negedge clk);
      check(cur_req, pla_out, model_eval(pla_in, fb_sel));
   endtask

   task automatic wr(input logic plane, input int row, input int col, input logic b);
      cfg_en = 1'b1; cfg_plane = plane; cfg_row = RW'(row); cfg_col = CW'(col); cfg_bit = b;
      tick();
      cfg_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(); tick();
      cur_req = "R9";
      check("R9 reset clears outputs", pla_out, '0);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [8:0] x;
      @(negedge clk);
      // R9: reset and an unprogrammed array
      do_reset();
      pla_in = '1; fb_sel = '1;
      tick();
      check("R9 unprogrammed all ones", pla_out, '0);

      // R1/R5: term0 = in0 & ~in1 shared by out0 and out4
      cur_req = "R1";
      wr(1'b0, 0, 0, 1'b1);
      wr(1'b0, 0, 3, 1'b1);
      cur_req = "R5";
      wr(1'b1, 0, 0, 1'b1);
      wr(1'b1, 0, 4, 1'b1);
      // R2: term1 empty feeds out5
      cur_req = "R2";
      wr(1'b1, 1, 5, 1'b1);
      // R4: term2 = in2 & ~in2 feeds out6
      cur_req = "R4";
      wr(1'b0, 2, 4, 1'b1);
      wr(1'b0, 2, 5, 1'b1);
      wr(1'b1, 2, 6, 1'b1);
      fb_sel = '0;
      pla_in = NI'(18'h00005);
      tick();
      check("R5 shared term drives out0 and out4", pla_out, 10'h031);
      pla_in = NI'(18'h00003);
      tick();
      check("R1 inverted literal blocks term", pla_out, 10'h020);
      pla_in = NI'(18'h00004);
      tick();
      check("R4 clash term stays low", pla_out[6], 1'b0);
      check("R2 empty term reads one", pla_out[5], 1'b1);

      // R10: same-cycle response without any clock edge
      cur_req = "R10";
      @(posedge clk); #1;
      pla_in = NI'(18'h00001);
      #1;
      check("R10 combinational response", pla_out, model_eval(pla_in, fb_sel));
      check("R10 combinational value", pla_out, 10'h031);
      @(negedge clk);

      // R6: out-of-range addresses change nothing
      cur_req = "R6";
      wr(1'b1, 50, 7, 1'b1);
      wr(1'b1, 3, 12, 1'b1);
      wr(1'b0, 1, 40, 1'b1);
      wr(1'b0, 63, 0, 1'b1);
      check("R6 out-of-range ignored", pla_out, 10'h031);
      wr(1'b1, 0, 4, 1'b0);
      check("R6 clearing an OR bit", pla_out, 10'h021);
      // R7: fields toggle with enable low
      cur_req = "R7";
      cfg_plane = 1'b1; cfg_row = 6'd1; cfg_col = 6'd9; cfg_bit = 1'b1;
      tick(); tick();
      cfg_plane = 1'b0; cfg_row = 6'd1; cfg_col = 6'd0;
      tick();
      check("R7 idle port leaves planes", pla_out, 10'h021);

      // R8: nine-input parity with three feedback paths
      do_reset();
      cur_req = "R8";
      for (int g = 0; g < 4; g++) begin
         for (int idx = 0; idx < 4; idx++) begin
            int m;
            int t;
            m = (idx == 0) ? 1 : (idx == 1) ? 2 : (idx == 2) ? 4 : 7;
            t = 4 * g + idx;
            for (int b = 0; b < 3; b++) begin
               int inp;
               inp = (g < 3) ? 3 * g + b : NI - NF + b;
               wr(1'b0, t, ((m >> b) & 1) != 0 ? 2 * inp : 2 * inp + 1, 1'b1);
            end
            wr(1'b1, t, g, 1'b1);
         end
      end
      fb_sel = '1;
      for (int n = 0; n < 24; n++) begin
         x = 9'($urandom);
         pla_in = {3'($urandom), 6'($urandom), x};
         tick();
         check("R8 parity after one feedback clock", {9'b0, pla_out[3]}, {9'b0, ^x});
         pla_in[NI-1:NI-NF] = ~pla_in[NI-1:NI-NF];
         tick();
         check("R8 feedback pins ignored", {9'b0, pla_out[3]}, {9'b0, ^x});
      end
      fb_sel = '0;
      pla_in = NI'(18'h28000);
      tick();
      check("R8 direct pins when unselected", {9'b0, pla_out[3]}, 10'h000);
      pla_in = NI'(18'h20000);
      tick();
      check("R8 direct pins odd", {9'b0, pla_out[3]}, 10'h001);

      // R3: random programs against the model
      cur_req = "R3";
      for (int n = 0; n < 3000; n++) begin
         pla_in = NI'($urandom);
         fb_sel = FBW'($urandom);
         if (($urandom % 3) == 0) begin
            cfg_en = 1'b1; cfg_plane = 1'($urandom);
            cfg_row = RW'($urandom); cfg_col = CW'($urandom); cfg_bit = 1'($urandom);
         end else cfg_en = 1'b0;
         tick();
      end
      cfg_en = 1'b0;
      tick();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule